// File: doc/BRIEF.md
# BCD calendar clock with alarm

This block keeps wall-clock time and a calendar in binary-coded decimal: seconds, minutes, hours, day of the week, date, month and two-digit year. A one-second tick is formed by counting pulses of a slow enable input, nominally 32768 per second. Software loads the fields through a byte-wide write port while counting is halted, then sets a run bit to start the clock. A combinational read port returns any register.

Two event sources sit beside the counters. A periodic selector raises a one-cycle pulse at a chosen rate, from every half second up to once a month. An alarm compares the minute, the hour and a seven-bit weekday enable mask against the time the clock is about to show when the seconds wrap to zero. On a match it sets a sticky flag, and it pulses an event output if the alarm interrupt is enabled.

The one-second divider is a two-state machine. In PS_STOPPED the divider count is held at zero. The STOP_TO_RUN transition is taken on the first clock after the run bit reads 1, and the state is then PS_RUNNING, where each enable pulse advances the count and the last count issues the second tick. The RUN_TO_STOP transition is taken on the first clock after the run bit reads 0.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the time reads 00:00:00 with weekday 0, date 01, month 01 and year 00. The control byte reads 0x02 (halted, 24-hour mode, periodic off), all alarm registers read 0, and all three outputs are low.
- R2: Seconds and minutes count 00 to 59 in BCD. A wrap from 59 to 00 carries into the next field, and a units digit of 9 carries into the tens digit.
- R3: In 24-hour mode (control bit 1 = 1) the hour counts 00 to 23, and the step from 23 to 00 advances the day.
- R4: In 12-hour mode (control bit 1 = 0) the hour runs 12, 01 to 11 for morning and 32, 21 to 31 for afternoon. The value 0x20 marks p.m., 11 steps to 32, 32 steps to 21, 12 steps to 01, and 31 steps to 12 and advances the day.
- R5: The weekday counts 0 to 6 (0 = Sunday), wraps to 0, and steps together with the date.
- R6: The date wraps after 31, 30 (months 04, 06, 09, 11) or 28/29 (month 02; 29 when the BCD year is divisible by 4). Month 12 wraps to 01 and carries into the year, which wraps 99 to 00.
- R7: One second is TICKS_PER_SEC enable pulses counted while running. With tick_en held high, the first second lands on the fifth rising edge after the edge that writes run = 1. With run = 0 or tick_en low, no field changes.
- R8: The alarm is checked only on the tick that wraps seconds to 00 and only while alarm-control bit 0 is 1. It matches when the new minute and hour equal the alarm minute and hour and mask bit [weekday] is 1. A match sets the flag (alarm-control bit 2), so at most one match occurs per minute.
- R9: The alarm event is a one-cycle pulse, issued on a match only when alarm-control bit 1 is 1. Writing the alarm-control register with bit 2 = 0 clears the flag; writing bit 2 = 1 leaves it unchanged.
- R10: The periodic select (control bits 4:2) gives the following pulses: 000 none; 001 every half second; 010 every second; 011 when seconds wrap to 00; 100 when minutes also wrap to 00; 101 at midnight (00:00:00, or 12:00:00 in 12-hour mode); 110 and 111 at midnight on date 01.
- R11: The new time, the alarm flag, the alarm event and the periodic pulse all appear together, in the cycle that follows the clock edge on which the second completes.
- R12: Register addresses: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 alarm minute, 8 alarm hour, 9 weekday mask, 10 control {sel[4:2], mode24[1], run[0]}, 11 alarm control {flag[2], irq enable[1], enable[0]}. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow time-base enable, one pulse per divider step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Combinational read data |
| alarm_evt | output | 1 | One-cycle alarm event pulse |
| alarm_flag | output | 1 | Sticky alarm match flag |
| periodic_irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
Once run is written at edge E0, the divider reaches the running state at E1. With the enable held high, the first second completes at E5. The updated fields, the alarm flag, the alarm event and the periodic pulse are all registered at E5, so each vector samples them at the falling edge after E5. The bench then writes run = 0, which takes effect by E8, one edge before the next second would complete at E9, so each vector sees exactly one advance. Half-second pulses land on every second edge from E3 on, and the window counts compare pulse totals rather than single-cycle levels.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_SEC   = 4'd0;
    localparam logic [ADDR_W-1:0] A_MIN   = 4'd1;
    localparam logic [ADDR_W-1:0] A_HOUR  = 4'd2;
    localparam logic [ADDR_W-1:0] A_WDAY  = 4'd3;
    localparam logic [ADDR_W-1:0] A_DATE  = 4'd4;
    localparam logic [ADDR_W-1:0] A_MON   = 4'd5;
    localparam logic [ADDR_W-1:0] A_YEAR  = 4'd6;
    localparam logic [ADDR_W-1:0] A_AMIN  = 4'd7;
    localparam logic [ADDR_W-1:0] A_AHOUR = 4'd8;
    localparam logic [ADDR_W-1:0] A_AMASK = 4'd9;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd10;
    localparam logic [ADDR_W-1:0] A_ACTL  = 4'd11;

    typedef enum logic [0:0] {
        PS_STOPPED = 1'b0,
        PS_RUNNING = 1'b1
    } ps_state_e;

    typedef enum logic [2:0] {
        PI_OFF   = 3'd0,
        PI_HALF  = 3'd1,
        PI_SEC   = 3'd2,
        PI_MIN   = 3'd3,
        PI_HOUR  = 3'd4,
        PI_DAY   = 3'd5,
        PI_MON_A = 3'd6,
        PI_MON_B = 3'd7
    } pi_sel_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
    } cal_t;

    // Two-digit BCD increment without range wrap.
    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        logic [3:0] hi;
        hi = v[7:4] + 4'd1;
        return (v[3:0] == 4'd9) ? {hi, 4'd0} : {v[7:4], v[3:0] + 4'd1};
    endfunction

    // BCD year divisible by four: even tens with 0/4/8, odd tens with 2/6.
    function automatic logic year_is_leap(input logic [7:0] y);
        logic [3:0] u;
        u = y[3:0];
        if (y[4]) return (u == 4'd2) || (u == 4'd6);
        return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
    endfunction

    function automatic logic [5:0] month_last_date(input logic [4:0] m, input logic [7:0] y);
        logic [5:0] r;
        case (m)
            5'h02:                      r = year_is_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
            default:                    r = 6'h31;
        endcase
        return r;
    endfunction

    function automatic logic [5:0] hour_step(input logic [5:0] h, input logic m24);
        logic [7:0] t;
        logic [5:0] r;
        t = bcd_inc8({2'b00, h});
        if (m24) begin
            r = (h == 6'h23) ? 6'h00 : t[5:0];
        end else begin
            case (h)
                6'h11:   r = 6'h32;
                6'h32:   r = 6'h21;
                6'h12:   r = 6'h01;
                6'h31:   r = 6'h12;
                default: r = t[5:0];
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic tick_en,
    output logic running,
    output logic sec_tick,
    output logic half_tick
);

    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST_C = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] MID_C  = CW'(TICKS_PER_SEC / 2 - 1);

    ps_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          at_last;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_STOPPED;
        else        state_q <= state_d;
    end

    // Transitions: STOP_TO_RUN on run_req, RUN_TO_STOP on its removal.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_STOPPED: if (run_req)  state_d = PS_RUNNING;
            PS_RUNNING: if (!run_req) state_d = PS_STOPPED;
        endcase
    end

    // Outputs.
    always_comb begin
        running   = 1'b0;
        unique case (state_q)
            PS_STOPPED: running = 1'b0;
            PS_RUNNING: running = 1'b1;
        endcase
        at_last   = (cnt_q == LAST_C);
        sec_tick  = running && tick_en && at_last;
        half_tick = running && tick_en && (at_last || (cnt_q == MID_C));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!running)     cnt_q <= '0;
        else if (tick_en)      cnt_q <= at_last ? '0 : cnt_q + CW'(1);
    end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sec_tick,
    input  logic              mode24,
    output cal_t              cal_q,
    output cal_t              cal_nxt
);

    logic       sec_wrap, min_wrap, day_wrap, date_wrap, mon_wrap;
    logic [7:0] sec_i, min_i, date_i, mon_i, year_i;
    logic [5:0] last_day;

    always_comb begin
        sec_i    = bcd_inc8({1'b0, cal_q.sec});
        min_i    = bcd_inc8({1'b0, cal_q.min});
        date_i   = bcd_inc8({2'b00, cal_q.date});
        mon_i    = bcd_inc8({3'b000, cal_q.month});
        year_i   = bcd_inc8(cal_q.year);
        last_day = month_last_date(cal_q.month, cal_q.year);

        sec_wrap  = (cal_q.sec == 7'h59);
        min_wrap  = sec_wrap && (cal_q.min == 7'h59);
        day_wrap  = min_wrap && (cal_q.hour == (mode24 ? 6'h23 : 6'h31));
        date_wrap = day_wrap && (cal_q.date == last_day);
        mon_wrap  = date_wrap && (cal_q.month == 5'h12);

        cal_nxt.sec   = sec_wrap ? 7'h00 : sec_i[6:0];
        cal_nxt.min   = sec_wrap ? ((cal_q.min == 7'h59) ? 7'h00 : min_i[6:0]) : cal_q.min;
        cal_nxt.hour  = min_wrap ? hour_step(cal_q.hour, mode24) : cal_q.hour;
        cal_nxt.wday  = day_wrap ? ((cal_q.wday == 3'd6) ? 3'd0 : cal_q.wday + 3'd1) : cal_q.wday;
        cal_nxt.date  = day_wrap ? (date_wrap ? 6'h01 : date_i[5:0]) : cal_q.date;
        cal_nxt.month = date_wrap ? (mon_wrap ? 5'h01 : mon_i[4:0]) : cal_q.month;
        cal_nxt.year  = mon_wrap ? ((cal_q.year == 8'h99) ? 8'h00 : year_i) : cal_q.year;
    end

    // A software write to a field takes priority over the tick for that field.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q.sec   <= 7'h00;
            cal_q.min   <= 7'h00;
            cal_q.hour  <= 6'h00;
            cal_q.wday  <= 3'd0;
            cal_q.date  <= 6'h01;
            cal_q.month <= 5'h01;
            cal_q.year  <= 8'h00;
        end else begin
            if (wr_en && wr_addr == A_SEC)       cal_q.sec   <= wr_data[6:0];
            else if (sec_tick)                   cal_q.sec   <= cal_nxt.sec;
            if (wr_en && wr_addr == A_MIN)       cal_q.min   <= wr_data[6:0];
            else if (sec_tick)                   cal_q.min   <= cal_nxt.min;
            if (wr_en && wr_addr == A_HOUR)      cal_q.hour  <= wr_data[5:0];
            else if (sec_tick)                   cal_q.hour  <= cal_nxt.hour;
            if (wr_en && wr_addr == A_WDAY)      cal_q.wday  <= wr_data[2:0];
            else if (sec_tick)                   cal_q.wday  <= cal_nxt.wday;
            if (wr_en && wr_addr == A_DATE)      cal_q.date  <= wr_data[5:0];
            else if (sec_tick)                   cal_q.date  <= cal_nxt.date;
            if (wr_en && wr_addr == A_MON)       cal_q.month <= wr_data[4:0];
            else if (sec_tick)                   cal_q.month <= cal_nxt.month;
            if (wr_en && wr_addr == A_YEAR)      cal_q.year  <= wr_data;
            else if (sec_tick)                   cal_q.year  <= cal_nxt.year;
        end
    end

endmodule

// File: rtl/rtc_event_unit.sv
module rtc_event_unit
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       half_tick,
    input  cal_t       cal_nxt,
    input  logic       mode24,
    input  logic [2:0] pi_sel,
    input  logic [6:0] al_min,
    input  logic [5:0] al_hour,
    input  logic [6:0] al_mask,
    input  logic       al_en,
    input  logic       al_irq_en,
    input  logic       flag_clr,
    output logic       alarm_evt,
    output logic       alarm_flag,
    output logic       periodic_irq
);

    logic       roll_sec, roll_min, roll_day, roll_mon;
    logic       al_hit, pi_fire;
    logic [7:0] mask_ext;
    pi_sel_e    sel;

    always_comb begin
        sel      = pi_sel_e'(pi_sel);
        mask_ext = {1'b0, al_mask};
        roll_sec = sec_tick && (cal_nxt.sec == 7'h00);
        roll_min = roll_sec && (cal_nxt.min == 7'h00);
        roll_day = roll_min && (cal_nxt.hour == (mode24 ? 6'h00 : 6'h12));
        roll_mon = roll_day && (cal_nxt.date == 6'h01);
        al_hit   = al_en && roll_sec && (cal_nxt.min == al_min)
                   && (cal_nxt.hour == al_hour) && mask_ext[cal_nxt.wday];
        pi_fire  = 1'b0;
        unique case (sel)
            PI_OFF:             pi_fire = 1'b0;
            PI_HALF:            pi_fire = half_tick;
            PI_SEC:             pi_fire = sec_tick;
            PI_MIN:             pi_fire = roll_sec;
            PI_HOUR:            pi_fire = roll_min;
            PI_DAY:             pi_fire = roll_day;
            PI_MON_A, PI_MON_B: pi_fire = roll_mon;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_evt    <= 1'b0;
            alarm_flag   <= 1'b0;
            periodic_irq <= 1'b0;
        end else begin
            alarm_evt    <= al_hit && al_irq_en;
            periodic_irq <= pi_fire;
            if (al_hit)        alarm_flag <= 1'b1;
            else if (flag_clr) alarm_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [3:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        alarm_evt,
    output logic        alarm_flag,
    output logic        periodic_irq
);

    logic       ctrl_run, ctrl_m24;
    logic [2:0] ctrl_sel;
    logic [6:0] al_min, al_mask;
    logic [5:0] al_hour;
    logic       al_en, al_irq_en;
    logic       running, sec_tick, half_tick, flag_clr;
    cal_t       cal_q, cal_nxt;
    logic [6:0] cur_sec;
    logic [2:0] cur_wday;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_run  <= 1'b0;
            ctrl_m24  <= 1'b1;
            ctrl_sel  <= 3'd0;
            al_min    <= 7'h00;
            al_hour   <= 6'h00;
            al_mask   <= 7'h00;
            al_en     <= 1'b0;
            al_irq_en <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    ctrl_run <= wr_data[0];
                    ctrl_m24 <= wr_data[1];
                    ctrl_sel <= wr_data[4:2];
                end
                A_ACTL: begin
                    al_en     <= wr_data[0];
                    al_irq_en <= wr_data[1];
                end
                A_AMIN:  al_min  <= wr_data[6:0];
                A_AHOUR: al_hour <= wr_data[5:0];
                A_AMASK: al_mask <= wr_data[6:0];
                default: ;
            endcase
        end
    end

    assign flag_clr = wr_en && (wr_addr == A_ACTL) && !wr_data[2];

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_req   (ctrl_run),
        .tick_en   (tick_en),
        .running   (running),
        .sec_tick  (sec_tick),
        .half_tick (half_tick)
    );

    rtc_time_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sec_tick (sec_tick),
        .mode24   (ctrl_m24),
        .cal_q    (cal_q),
        .cal_nxt  (cal_nxt)
    );

    rtc_event_unit u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .sec_tick     (sec_tick),
        .half_tick    (half_tick),
        .cal_nxt      (cal_nxt),
        .mode24       (ctrl_m24),
        .pi_sel       (ctrl_sel),
        .al_min       (al_min),
        .al_hour      (al_hour),
        .al_mask      (al_mask),
        .al_en        (al_en),
        .al_irq_en    (al_irq_en),
        .flag_clr     (flag_clr),
        .alarm_evt    (alarm_evt),
        .alarm_flag   (alarm_flag),
        .periodic_irq (periodic_irq)
    );

    assign cur_sec  = cal_q.sec;
    assign cur_wday = cal_q.wday;

    always_comb begin
        rd_data = 8'h00;
        case (rd_addr)
            A_SEC:   rd_data = {1'b0, cal_q.sec};
            A_MIN:   rd_data = {1'b0, cal_q.min};
            A_HOUR:  rd_data = {2'b00, cal_q.hour};
            A_WDAY:  rd_data = {5'b00000, cal_q.wday};
            A_DATE:  rd_data = {2'b00, cal_q.date};
            A_MON:   rd_data = {3'b000, cal_q.month};
            A_YEAR:  rd_data = cal_q.year;
            A_AMIN:  rd_data = {1'b0, al_min};
            A_AHOUR: rd_data = {2'b00, al_hour};
            A_AMASK: rd_data = {1'b0, al_mask};
            A_CTRL:  rd_data = {3'b000, ctrl_sel, ctrl_m24, ctrl_run};
            A_ACTL:  rd_data = {5'b00000, alarm_flag, al_irq_en, al_en};
            default: rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_sva.sv
module rtc_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       running,
    input logic [6:0] sec_q,
    input logic [2:0] wday_q,
    input logic [2:0] sel_q,
    input logic       alarm_evt,
    input logic       alarm_flag,
    input logic       periodic_irq
);

    p_sec_digits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[3:0] <= 4'd9) && (sec_q[6:4] <= 3'd5));

    p_wday_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wday_q <= 3'd6);

    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_en) |=> $stable(sec_q));

    p_single_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> !alarm_evt);

    p_evt_with_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> alarm_flag);

    p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'd0) |=> !periodic_irq);

endmodule

bind bcd_calendar_rtc rtc_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .running      (running),
    .sec_q        (cur_sec),
    .wday_q       (cur_wday),
    .sel_q        (ctrl_sel),
    .alarm_evt    (alarm_evt),
    .alarm_flag   (alarm_flag),
    .periodic_irq (periodic_irq)
);

// File: tb/bcd_calendar_rtc_tb.sv
module bcd_calendar_rtc_tb;

    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       alarm_evt, alarm_flag, periodic_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bcd_calendar_rtc #(.TICKS_PER_SEC(TPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .alarm_evt(alarm_evt), .alarm_flag(alarm_flag), .periodic_irq(periodic_irq)
    );

    typedef struct packed {
        logic [7:0] s, mi, h, wd, d, mo, y;
        logic       m24;
        logic [2:0] sel;
        logic [7:0] amin, ahour, amask;
        logic       aen, airq;
        logic [7:0] es, emi, eh, ewd, ed, emo, ey;
        logic       eirq, eevt, eflag;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VT [NV] = '{
        '{8'h05,8'h00,8'h00,8'h2,8'h01,8'h01,8'h13,1'b1,3'd2,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h06,8'h00,8'h00,8'h2,8'h01,8'h01,8'h13,1'b1,1'b0,1'b0},
        '{8'h59,8'h00,8'h00,8'h2,8'h01,8'h01,8'h13,1'b1,3'd3,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h01,8'h00,8'h2,8'h01,8'h01,8'h13,1'b1,1'b0,1'b0},
        '{8'h59,8'h59,8'h23,8'h6,8'h31,8'h12,8'h99,1'b1,3'd6,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h0,8'h01,8'h01,8'h00,1'b1,1'b0,1'b0},
        '{8'h59,8'h59,8'h23,8'h4,8'h28,8'h02,8'h13,1'b1,3'd5,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h5,8'h01,8'h03,8'h13,1'b1,1'b0,1'b0},
        '{8'h59,8'h59,8'h23,8'h3,8'h28,8'h02,8'h12,1'b1,3'd4,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h4,8'h29,8'h02,8'h12,1'b1,1'b0,1'b0},
        '{8'h59,8'h59,8'h23,8'h1,8'h29,8'h02,8'h16,1'b1,3'd7,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h2,8'h01,8'h03,8'h16,1'b1,1'b0,1'b0},
        '{8'h59,8'h59,8'h23,8'h0,8'h30,8'h04,8'h20,1'b1,3'd3,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h1,8'h01,8'h05,8'h20,1'b1,1'b0,1'b0},
        '{8'h59,8'h59,8'h11,8'h1,8'h10,8'h06,8'h21,1'b0,3'd5,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h00,8'h32,8'h1,8'h10,8'h06,8'h21,1'b0,1'b0,1'b0},
        '{8'h59,8'h59,8'h31,8'h5,8'h15,8'h07,8'h21,1'b0,3'd5,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h00,8'h12,8'h6,8'h16,8'h07,8'h21,1'b1,1'b0,1'b0},
        '{8'h59,8'h59,8'h12,8'h5,8'h16,8'h07,8'h21,1'b0,3'd4,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h00,8'h01,8'h5,8'h16,8'h07,8'h21,1'b1,1'b0,1'b0},
        '{8'h59,8'h59,8'h32,8'h5,8'h16,8'h07,8'h21,1'b0,3'd0,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h00,8'h21,8'h5,8'h16,8'h07,8'h21,1'b0,1'b0,1'b0},
        '{8'h59,8'h59,8'h09,8'h3,8'h05,8'h08,8'h22,1'b1,3'd0,8'h00,8'h10,8'h08,1'b1,1'b1, 8'h00,8'h00,8'h10,8'h3,8'h05,8'h08,8'h22,1'b0,1'b1,1'b1},
        '{8'h59,8'h59,8'h09,8'h3,8'h05,8'h08,8'h22,1'b1,3'd0,8'h00,8'h10,8'h77,1'b1,1'b1, 8'h00,8'h00,8'h10,8'h3,8'h05,8'h08,8'h22,1'b0,1'b0,1'b0},
        '{8'h59,8'h59,8'h09,8'h3,8'h05,8'h08,8'h22,1'b1,3'd0,8'h00,8'h10,8'h08,1'b1,1'b0, 8'h00,8'h00,8'h10,8'h3,8'h05,8'h08,8'h22,1'b0,1'b0,1'b1},
        '{8'h59,8'h59,8'h09,8'h3,8'h05,8'h08,8'h22,1'b1,3'd0,8'h00,8'h10,8'h7F,1'b0,1'b1, 8'h00,8'h00,8'h10,8'h3,8'h05,8'h08,8'h22,1'b0,1'b0,1'b0},
        '{8'h00,8'h00,8'h10,8'h3,8'h05,8'h08,8'h22,1'b1,3'd0,8'h00,8'h10,8'h7F,1'b1,1'b1, 8'h01,8'h00,8'h10,8'h3,8'h05,8'h08,8'h22,1'b0,1'b0,1'b0},
        '{8'h59,8'h59,8'h23,8'h2,8'h31,8'h01,8'h14,1'b1,3'd2,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h3,8'h01,8'h02,8'h14,1'b1,1'b0,1'b0},
        '{8'h59,8'h19,8'h07,8'h2,8'h11,8'h11,8'h14,1'b1,3'd0,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h20,8'h07,8'h2,8'h11,8'h11,8'h14,1'b0,1'b0,1'b0},
        '{8'h59,8'h59,8'h23,8'h0,8'h28,8'h02,8'h00,1'b1,3'd0,8'h00,8'h00,8'h00,1'b0,1'b0, 8'h00,8'h00,8'h00,8'h1,8'h29,8'h02,8'h00,1'b0,1'b0,1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic run_vec(input int i);
        logic [7:0] v;
        vec_t t;
        t = VT[i];
        wr(4'd10, {3'b000, t.sel, t.m24, 1'b0});
        wr(4'd11, 8'h00);
        wr(4'd0, t.s);  wr(4'd1, t.mi); wr(4'd2, t.h); wr(4'd3, t.wd);
        wr(4'd4, t.d);  wr(4'd5, t.mo); wr(4'd6, t.y);
        wr(4'd7, t.amin); wr(4'd8, t.ahour); wr(4'd9, t.amask);
        wr(4'd11, {6'b000000, t.airq, t.aen});
        wr(4'd10, {3'b000, t.sel, t.m24, 1'b1});
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk($sformatf("R10 R11 vec%0d periodic_irq", i), {7'd0, periodic_irq}, {7'd0, t.eirq});
        chk($sformatf("R8 R9 R11 vec%0d alarm_evt", i), {7'd0, alarm_evt}, {7'd0, t.eevt});
        chk($sformatf("R8 vec%0d alarm_flag", i), {7'd0, alarm_flag}, {7'd0, t.eflag});
        wr(4'd10, {3'b000, t.sel, t.m24, 1'b0});
        rd(4'd0, v); chk($sformatf("R2 vec%0d sec", i), v, t.es);
        rd(4'd1, v); chk($sformatf("R2 vec%0d min", i), v, t.emi);
        rd(4'd2, v); chk($sformatf("R3 R4 vec%0d hour", i), v, t.eh);
        rd(4'd3, v); chk($sformatf("R5 vec%0d wday", i), v, t.ewd);
        rd(4'd4, v); chk($sformatf("R6 vec%0d date", i), v, t.ed);
        rd(4'd5, v); chk($sformatf("R6 vec%0d month", i), v, t.emo);
        rd(4'd6, v); chk($sformatf("R6 vec%0d year", i), v, t.ey);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int cnt_p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R12: reset state through the read port
        rd(4'd0, v);  chk("R1 reset sec", v, 8'h00);
        rd(4'd2, v);  chk("R1 reset hour", v, 8'h00);
        rd(4'd3, v);  chk("R1 reset wday", v, 8'h00);
        rd(4'd4, v);  chk("R1 reset date", v, 8'h01);
        rd(4'd5, v);  chk("R1 reset month", v, 8'h01);
        rd(4'd6, v);  chk("R1 reset year", v, 8'h00);
        rd(4'd10, v); chk("R1 R12 reset ctrl", v, 8'h02);
        rd(4'd11, v); chk("R1 R12 reset alarm ctrl", v, 8'h00);
        rd(4'd13, v); chk("R12 unused address", v, 8'h00);
        chk("R1 reset outputs", {5'd0, alarm_evt, alarm_flag, periodic_irq}, 8'h00);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R9: flag write-1 ignored, write-0 clears
        run_vec(13);
        wr(4'd11, 8'h04);
        chk("R9 flag kept on write 1", {7'd0, alarm_flag}, 8'h01);
        wr(4'd11, 8'h00);
        chk("R9 flag cleared on write 0", {7'd0, alarm_flag}, 8'h00);

        // R7: halted clock stays frozen
        repeat (20) @(negedge clk);
        rd(4'd0, v); chk("R7 halted sec frozen", v, 8'h00);

        // R7: running without enable pulses does not advance
        tick_en = 1'b0;
        wr(4'd10, 8'h03);
        repeat (30) @(negedge clk);
        rd(4'd0, v); chk("R7 no enable no advance", v, 8'h00);
        wr(4'd10, 8'h02);
        tick_en = 1'b1;

        // R10: half-second rate, edges E1..E16 after the run write
        wr(4'd10, 8'h07);
        cnt_p = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (periodic_irq) cnt_p++;
        end
        chk("R10 half-second pulse count", 8'(cnt_p), 8'd7);
        wr(4'd10, 8'h02);
        repeat (4) @(negedge clk);

        // R10: one-second rate over the same window
        wr(4'd10, 8'h0B);
        cnt_p = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (periodic_irq) cnt_p++;
        end
        chk("R10 one-second pulse count", 8'(cnt_p), 8'd3);
        wr(4'd10, 8'h02);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule